// File: doc/BRIEF.md
# 64b/66b Receive Block Decoder

This block turns a stream of descrambled 66-bit line blocks into a packet stream. Each output word carries 64 data bits, a 3-bit valid-byte code, an end-of-packet flag and an abort flag. A block is accepted in every cycle where the input valid is high, because the input has no backpressure. The output uses a valid/ready handshake.

There is no packet buffer. The decoder holds one pending word so that a terminate block can mark an earlier word as the last one. Beyond that pending word there is only the single output register. When a word has to enter that register while it still holds an unaccepted word, the packet in flight is given up. An abort word is emitted instead, and the rest of that packet is discarded.

Alongside the packet path, the block tracks link-up from sync-header quality. It also reports local and remote fault conditions taken from fault ordered sets, and an external PHY-fault input.

Top module: `pcs66_rx_decoder`

## Requirements
- R1: The sync header is `blk_data[1:0]`, and the payload is `blk_data[65:2]`, with payload byte k at payload bits [8k+7:8k]. Header 2'b01 is a data block and 2'b10 is a control block. Headers 2'b00 and 2'b11 are invalid, and an invalid header inside a packet aborts that packet.
- R2: A control block whose type byte (payload byte 0) is 0x78 opens a packet. None of its payload is forwarded. A start block is honoured only outside a packet.
- R3: Each data block inside a packet is forwarded as one word with the payload unchanged, byte code 0 (all 8 bytes valid), in arrival order.
- R4: Terminate types 0x87, 0x99, 0xAA, 0xB4, 0xCC, 0xD2, 0xE1 and 0xFF close the packet with 0 to 7 trailing bytes, in that order. For a nonzero count n, a final word carries payload bytes 1..n in output bytes 0..n-1, zero in the bytes above them, byte code n and LAST.
- R5: A terminate with 0 trailing bytes sets LAST on the last data word. If no data word preceded it, a single abort word is emitted.
- R6: An abort word has valid, ABORT and LAST high, byte code 0 and zero data. If a word must enter the output register while it holds an unaccepted word, the packet is aborted and discarded until the next start. The held word stays stable until it is accepted, and the abort word follows it.
- R7: Blocks outside a packet other than a start are ignored and produce no output. Inside a packet, any control block that is neither a terminate nor valid data aborts the packet.
- R8: A control block of type 0x4B with sequence code 0x01 in payload byte 3 raises `local_fault` on the next cycle. With sequence code 0x02 it raises `remote_fault` on the next cycle.
- R9: Each fault flag clears on the 128th valid block received after its last matching ordered set that does not itself carry that ordered set. It is still high after 127 such blocks.
- R10: `phy_fault` high raises `local_fault` and drops `link_up` on the next cycle.
- R11: `link_up` rises on the 64th consecutive valid block with a valid header. It falls on the cycle after any valid block with an invalid header.
- R12: After reset, `m_valid`, `link_up`, `local_fault` and `remote_fault` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_valid | input | 1 | A line block is present this cycle |
| blk_data | input | 66 | Descrambled block: header [1:0], payload [65:2] |
| phy_fault | input | 1 | External PHY fault; forces local fault and link down |
| m_valid | output | 1 | Output word valid |
| m_ready | input | 1 | Downstream accepts the output word |
| m_data | output | 64 | Output data, byte 0 in bits [7:0] |
| m_bytes | output | 3 | Valid-byte code: 0 means 8 bytes, 1..7 on a LAST word |
| m_last | output | 1 | Final word of a packet |
| m_abort | output | 1 | Packet was aborted |
| link_up | output | 1 | Block lock achieved |
| local_fault | output | 1 | Local fault indication |
| remote_fault | output | 1 | Remote fault indication |

## Verification
A wrong framer state shows up on the output port in one of three ways: a word appears that was never expected, a packet loses its LAST marking, or an abort word is missing. The full cost of such a fault is visible within two cycles of the terminate block, because the tail word reaches the output register one cycle after the terminate and is presented in the next cycle. A wrong byte code or a misplaced tail byte is caught by sweeping every terminate type against data runs of zero to three words. The lock and fault counters are probed exactly at their thresholds, one block short of each threshold and at it, so an off-by-one shows as a flag one cycle early or late.

// File: rtl/pcs66_rx_pkg.sv
package pcs66_rx_pkg;

   localparam int PAYLOAD_W = 64;
   localparam int NBYTES    = PAYLOAD_W / 8;
   localparam int CNT_W     = $clog2(NBYTES);
   localparam int BLOCK_W   = PAYLOAD_W + 2;

   localparam logic [1:0] HDR_DATA = 2'b01;
   localparam logic [1:0] HDR_CTRL = 2'b10;

   localparam logic [7:0] TYPE_START = 8'h78;
   localparam logic [7:0] TYPE_OSET  = 8'h4B;

   typedef enum logic [1:0] {
      FR_IDLE,
      FR_ACTIVE,
      FR_DROP
   } fr_state_e;

   typedef struct packed {
      logic [PAYLOAD_W-1:0] data;
      logic [CNT_W-1:0]     bytes;
      logic                 last;
      logic                 abort;
   } pkt_word_t;

   typedef struct packed {
      logic             hit;
      logic [CNT_W-1:0] count;
   } term_info_t;

   // Terminate block types, ordered by trailing byte count
   function automatic term_info_t term_decode(input logic [7:0] btype);
      term_info_t r;
      r.hit   = 1'b1;
      r.count = '0;
      case (btype)
         8'h87:   r.count = 3'd0;
         8'h99:   r.count = 3'd1;
         8'hAA:   r.count = 3'd2;
         8'hB4:   r.count = 3'd3;
         8'hCC:   r.count = 3'd4;
         8'hD2:   r.count = 3'd5;
         8'hE1:   r.count = 3'd6;
         8'hFF:   r.count = 3'd7;
         default: r.hit = 1'b0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pcs66_link_mon.sv
module pcs66_link_mon #(
   parameter int LOCK_BLOCKS = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic blk_valid,
   input  logic hdr_ok,
   input  logic phy_fault,
   output logic link_up
);
   localparam int CW = $clog2(LOCK_BLOCKS);

   generate
      if (LOCK_BLOCKS < 2) begin : g_bad_lock
         $error("LOCK_BLOCKS must be at least 2");
      end
   endgenerate

   logic [CW-1:0] good_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         good_cnt <= '0;
         link_up  <= 1'b0;
      end else if (phy_fault) begin
         good_cnt <= '0;
         link_up  <= 1'b0;
      end else if (blk_valid) begin
         if (!hdr_ok) begin
            good_cnt <= '0;
            link_up  <= 1'b0;
         end else if (!link_up) begin
            if (good_cnt == CW'(LOCK_BLOCKS - 1)) begin
               link_up  <= 1'b1;
               good_cnt <= '0;
            end else begin
               good_cnt <= good_cnt + 1'b1;
            end
         end
      end
   end

   // R11
   bad_hdr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blk_valid && !hdr_ok |=> !link_up);

   // R10
   phy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phy_fault |=> !link_up);

   // R11
   rise_on_good_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !link_up ##1 link_up |-> $past(blk_valid && hdr_ok && !phy_fault));

endmodule

// File: rtl/pcs66_fault_mon.sv
module pcs66_fault_mon #(
   parameter int CLEAR_BLOCKS = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic blk_valid,
   input  logic seen,
   input  logic force_set,
   output logic fault
);
   localparam int CW = $clog2(CLEAR_BLOCKS);

   generate
      if (CLEAR_BLOCKS < 2) begin : g_bad_clear
         $error("CLEAR_BLOCKS must be at least 2");
      end
   endgenerate

   logic [CW-1:0] quiet_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fault     <= 1'b0;
         quiet_cnt <= '0;
      end else if (force_set || (blk_valid && seen)) begin
         fault     <= 1'b1;
         quiet_cnt <= '0;
      end else if (blk_valid && fault) begin
         if (quiet_cnt == CW'(CLEAR_BLOCKS - 1)) begin
            fault     <= 1'b0;
            quiet_cnt <= '0;
         end else begin
            quiet_cnt <= quiet_cnt + 1'b1;
         end
      end
   end

   // R8
   set_on_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      blk_valid && seen |=> fault);

   // R9
   no_clear_without_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault && !blk_valid |=> fault);

endmodule

// File: rtl/pcs66_framer.sv
module pcs66_framer
   import pcs66_rx_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 blk_valid,
   input  logic [1:0]           hdr,
   input  logic [PAYLOAD_W-1:0] payload,
   input  logic                 m_ready,
   output logic                 m_valid,
   output pkt_word_t            m_word
);
   fr_state_e  st, st_n;
   pkt_word_t  pend_w, pend_w_n;
   logic       pend_v, pend_v_n;
   pkt_word_t  out_w, out_w_n;
   logic       out_v, out_v_n;
   logic       abort_q, abort_n;

   logic       is_data, is_ctrl, out_free, need_push, new_abort;
   pkt_word_t  push_w, tail_w, abort_w;
   term_info_t term;

   assign is_data  = (hdr == HDR_DATA);
   assign is_ctrl  = (hdr == HDR_CTRL);
   assign term     = term_decode(payload[7:0]);
   assign out_free = !out_v || m_ready;

   always_comb begin
      abort_w = '0;
      abort_w.last  = 1'b1;
      abort_w.abort = 1'b1;
      tail_w = '0;
      tail_w.bytes = term.count;
      tail_w.last  = 1'b1;
      for (int k = 0; k < NBYTES - 1; k++) begin
         if (k < int'(term.count))
            tail_w.data[8*k +: 8] = payload[8*(k+1) +: 8];
      end
   end

   always_comb begin
      st_n      = st;
      pend_w_n  = pend_w;
      pend_v_n  = pend_v;
      out_w_n   = out_w;
      out_v_n   = out_v && !m_ready;
      need_push = 1'b0;
      push_w    = pend_w;
      new_abort = 1'b0;

      // a finished tail leaves the pending slot on the next cycle
      if (pend_v && pend_w.last) begin
         need_push = 1'b1;
         pend_v_n  = 1'b0;
      end

      if (blk_valid) begin
         case (st)
            FR_ACTIVE: begin
               if (is_data) begin
                  need_push = pend_v;
                  pend_w_n  = '{data: payload, bytes: '0, last: 1'b0, abort: 1'b0};
                  pend_v_n  = 1'b1;
               end else if (is_ctrl && term.hit) begin
                  st_n = FR_IDLE;
                  if (term.count == '0) begin
                     pend_v_n = 1'b0;
                     if (pend_v) begin
                        need_push   = 1'b1;
                        push_w.last = 1'b1;
                     end else begin
                        new_abort = 1'b1;
                     end
                  end else begin
                     need_push = pend_v;
                     pend_w_n  = tail_w;
                     pend_v_n  = 1'b1;
                  end
               end else begin
                  new_abort = 1'b1;
                  pend_v_n  = 1'b0;
                  st_n      = FR_DROP;
               end
            end
            default: begin
               if (is_ctrl && payload[7:0] == TYPE_START) begin
                  st_n = FR_ACTIVE;
                  if (!(pend_v && pend_w.last))
                     pend_v_n = 1'b0;
               end
            end
         endcase
      end

      abort_n = abort_q && !out_free;
      if (abort_q && out_free) begin
         out_w_n = abort_w;
         out_v_n = 1'b1;
      end
      if (need_push) begin
         if (out_free && !abort_q) begin
            out_w_n = push_w;
            out_v_n = 1'b1;
         end else begin
            new_abort = 1'b1;
            pend_v_n  = 1'b0;
            if (st_n == FR_ACTIVE)
               st_n = FR_DROP;
         end
      end
      if (new_abort)
         abort_n = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= FR_IDLE;
         pend_w  <= '0;
         pend_v  <= 1'b0;
         out_w   <= '0;
         out_v   <= 1'b0;
         abort_q <= 1'b0;
      end else begin
         st      <= st_n;
         pend_w  <= pend_w_n;
         pend_v  <= pend_v_n;
         out_w   <= out_w_n;
         out_v   <= out_v_n;
         abort_q <= abort_n;
      end
   end

   assign m_valid = out_v;
   assign m_word  = out_w;

   // R6
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid && !m_ready |=> m_valid && $stable(m_word));

   // R4
   tail_is_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid && m_word.bytes != '0 |-> m_word.last && !m_word.abort);

   // R6
   abort_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
      m_valid && m_word.abort |-> m_word.last && m_word.data == '0);

endmodule

// File: rtl/pcs66_rx_decoder.sv
module pcs66_rx_decoder
   import pcs66_rx_pkg::*;
#(
   parameter int         LOCK_BLOCKS  = 64,
   parameter int         FAULT_CLEAR  = 128,
   parameter logic [7:0] LOCAL_SEQ    = 8'h01,
   parameter logic [7:0] REMOTE_SEQ   = 8'h02
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               blk_valid,
   input  logic [BLOCK_W-1:0] blk_data,
   input  logic               phy_fault,
   output logic               m_valid,
   input  logic               m_ready,
   output logic [PAYLOAD_W-1:0] m_data,
   output logic [CNT_W-1:0]   m_bytes,
   output logic               m_last,
   output logic               m_abort,
   output logic               link_up,
   output logic               local_fault,
   output logic               remote_fault
);
   localparam int NKINDS = 2;

   logic [1:0]           hdr;
   logic [PAYLOAD_W-1:0] payload;
   logic                 hdr_ok, oset;
   logic [NKINDS-1:0]    fault_vec;
   pkt_word_t            word;

   assign hdr     = blk_data[1:0];
   assign payload = blk_data[BLOCK_W-1:2];
   assign hdr_ok  = (hdr == HDR_DATA) || (hdr == HDR_CTRL);
   assign oset    = (hdr == HDR_CTRL) && (payload[7:0] == TYPE_OSET);

   pcs66_link_mon #(.LOCK_BLOCKS(LOCK_BLOCKS)) u_link (
      .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .hdr_ok(hdr_ok),
      .phy_fault(phy_fault), .link_up(link_up)
   );

   generate
      for (genvar g = 0; g < NKINDS; g++) begin : g_fault
         localparam logic [7:0] SEQ = (g == 0) ? LOCAL_SEQ : REMOTE_SEQ;
         logic force_in;
         if (g == 0) begin : g_forced
            assign force_in = phy_fault;
         end else begin : g_free
            assign force_in = 1'b0;
         end
         pcs66_fault_mon #(.CLEAR_BLOCKS(FAULT_CLEAR)) u_fault (
            .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid),
            .seen(oset && payload[31:24] == SEQ),
            .force_set(force_in), .fault(fault_vec[g])
         );
      end
   endgenerate

   assign local_fault  = fault_vec[0];
   assign remote_fault = fault_vec[1];

   pcs66_framer u_framer (
      .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .hdr(hdr),
      .payload(payload), .m_ready(m_ready), .m_valid(m_valid), .m_word(word)
   );

   assign m_data  = word.data;
   assign m_bytes = word.bytes;
   assign m_last  = word.last;
   assign m_abort = word.abort;

   // R10
   phy_forces_local_chk: assert property (@(posedge clk) disable iff (!rst_n)
      phy_fault |=> local_fault);

   // R12
   reset_quiet_chk: assert property (@(posedge clk)
      !rst_n |=> !m_valid && !link_up && !local_fault && !remote_fault);

endmodule

// File: tb/test_pcs66_rx_decoder.sv
module test_pcs66_rx_decoder;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        blk_valid = 1'b0;
   logic [65:0] blk_data = '0;
   logic        phy_fault = 1'b0;
   logic        m_ready = 1'b1;
   logic        m_valid, m_last, m_abort, link_up, local_fault, remote_fault;
   logic [63:0] m_data;
   logic [2:0]  m_bytes;

   int checks = 0;
   int fails  = 0;

   logic [63:0] rec_data  [0:15];
   logic [2:0]  rec_bytes [0:15];
   logic        rec_last  [0:15];
   logic        rec_abort [0:15];
   int          rec_n = 0;

   always #2 clk = ~clk;

   pcs66_rx_decoder i_pcs66_rx_decoder (
      .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_data(blk_data),
      .phy_fault(phy_fault), .m_valid(m_valid), .m_ready(m_ready),
      .m_data(m_data), .m_bytes(m_bytes), .m_last(m_last), .m_abort(m_abort),
      .link_up(link_up), .local_fault(local_fault), .remote_fault(remote_fault)
   );

   always @(negedge clk) begin
      if (rst_n && m_valid && m_ready && rec_n < 16) begin
         rec_data[rec_n]  <= m_data;
         rec_bytes[rec_n] <= m_bytes;
         rec_last[rec_n]  <= m_last;
         rec_abort[rec_n] <= m_abort;
         rec_n <= rec_n + 1;
      end
   end

   task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic blk(input logic [1:0] h, input logic [63:0] p);
      blk_valid = 1'b1;
      blk_data  = {p, h};
      @(posedge clk); #1;
      blk_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) blk(2'b10, 64'h1E);
   endtask

   function automatic logic [7:0] term_type(input int n);
      case (n)
         0: return 8'h87; 1: return 8'h99; 2: return 8'hAA; 3: return 8'hB4;
         4: return 8'hCC; 5: return 8'hD2; 6: return 8'hE1; default: return 8'hFF;
      endcase
   endfunction

   function automatic logic [63:0] dpay(input int i, input int d, input int n);
      return {16'hC0DE, 8'(i), 8'(d), 8'(n), 24'h5A1234};
   endfunction

   function automatic logic [63:0] tpay(input int n);
      logic [63:0] p;
      p[7:0] = term_type(n);
      for (int k = 1; k < 8; k++) p[8*k +: 8] = 8'(8'h30 + k + 16 * n);
      return p;
   endfunction

   task automatic clear_rec();
      @(posedge clk); #1;
      rec_n = 0;
   endtask

   initial begin
      #(4 * 200000);
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R12
      check(!m_valid && !link_up && !local_fault && !remote_fault, "R12 reset state",
            {m_valid, link_up, local_fault, remote_fault}, 0);

      // R11: lock after 64 consecutive valid headers
      idle(63);
      check(link_up == 1'b0, "R11 no lock after 63", link_up, 0);
      idle(1);
      check(link_up == 1'b1, "R11 lock on 64th", link_up, 1);

      // R7: blocks outside a packet are ignored
      clear_rec();
      blk(2'b01, 64'h1111);
      blk(2'b10, {56'hABCDEF, 8'h99});
      blk(2'b10, 64'h87);
      idle(3);
      check(rec_n == 0 && !m_valid, "R7 ignored outside packet", rec_n, 0);

      // R2 R3 R4 R5: sweep data lengths and terminate types
      for (int d = 0; d < 4; d++) begin
         for (int n = 0; n < 8; n++) begin
            int exp_n;
            logic ok;
            logic [63:0] tp, td;
            clear_rec();
            blk(2'b10, {56'hFFEEDDCCBBAA99, 8'h78});
            for (int i = 0; i < d; i++) blk(2'b01, dpay(i, d, n));
            tp = tpay(n);
            blk(2'b10, tp);
            idle(3);
            exp_n = (d == 0 && n == 0) ? 1 : d + ((n > 0) ? 1 : 0);
            ok = (rec_n == exp_n);
            if (ok && d == 0 && n == 0)
               ok = rec_abort[0] && rec_last[0] && rec_bytes[0] == 0 && rec_data[0] == 0;
            else if (ok) begin
               for (int i = 0; i < d; i++)
                  if (rec_data[i] !== dpay(i, d, n) || rec_bytes[i] != 0 || rec_abort[i] ||
                      rec_last[i] != (n == 0 && i == d - 1)) ok = 1'b0;
               if (n > 0) begin
                  td = '0;
                  for (int k = 0; k < n; k++) td[8*k +: 8] = tp[8*(k+1) +: 8];
                  if (rec_data[d] !== td || rec_bytes[d] != 3'(n) || !rec_last[d] || rec_abort[d])
                     ok = 1'b0;
               end
            end
            if (d == 0 && n == 0)
               check(ok, "R5 runt packet gives abort word", rec_n, exp_n);
            else if (n == 0)
               check(ok, "R5 zero-byte terminate marks last", rec_n, exp_n);
            else
               check(ok, "R4 tail bytes and count (R3 data words)", rec_n, exp_n);
         end
      end

      // R6: stall during a packet
      clear_rec();
      m_ready = 1'b0;
      blk(2'b10, 64'h78);
      blk(2'b01, 64'hD1);
      blk(2'b01, 64'hD2);
      blk(2'b01, 64'hD3);
      blk(2'b10, 64'h4433_2211_B4);
      idle(2);
      check(m_valid && !m_abort && m_data == 64'hD1, "R6 held word stable", m_data, 64'hD1);
      m_ready = 1'b1;
      idle(4);
      check(rec_n == 2 && rec_data[0] == 64'hD1 && !rec_last[0] &&
            rec_abort[1] && rec_last[1] && rec_bytes[1] == 0 && rec_data[1] == 0,
            "R6 abort after stall", rec_n, 2);
      clear_rec();
      blk(2'b10, 64'h78);
      blk(2'b01, 64'hE1);
      blk(2'b10, 64'h87);
      idle(3);
      check(rec_n == 1 && rec_data[0] == 64'hE1 && rec_last[0] && !rec_abort[0],
            "R6 recovery after abort", rec_n, 1);

      // R1: invalid headers abort a packet in progress
      for (int b = 0; b < 2; b++) begin
         clear_rec();
         blk(2'b10, 64'h78);
         blk(2'b01, 64'hA1);
         blk(2'b01, 64'hA2);
         blk(b == 0 ? 2'b00 : 2'b11, 64'hA3);
         check(link_up == 1'b0, "R11 link drops on bad header", link_up, 0);
         blk(2'b01, 64'hA4);
         blk(2'b10, 64'h99);
         idle(3);
         check(rec_n == 2 && rec_data[0] == 64'hA1 && rec_abort[1] && rec_last[1],
               "R1 bad header aborts packet", rec_n, 2);
      end

      // R7: non-terminate control inside a packet
      clear_rec();
      blk(2'b10, 64'h78);
      blk(2'b01, 64'hB1);
      blk(2'b10, 64'h1E);
      blk(2'b01, 64'hB2);
      blk(2'b10, 64'h87);
      idle(3);
      check(rec_n == 1 && rec_abort[0] && rec_last[0], "R7 control inside packet aborts", rec_n, 1);

      // R8 R9: local fault ordered set
      blk(2'b10, {32'h0, 8'h01, 16'h0, 8'h4B});
      check(local_fault && !remote_fault, "R8 local fault set", {local_fault, remote_fault}, 2);
      idle(127);
      check(local_fault == 1'b1, "R9 local held after 127", local_fault, 1);
      idle(1);
      check(local_fault == 1'b0, "R9 local clears on 128th", local_fault, 0);

      blk(2'b10, {32'h0, 8'h02, 16'h0, 8'h4B});
      check(remote_fault && !local_fault, "R8 remote fault set", {local_fault, remote_fault}, 1);
      idle(127);
      check(remote_fault == 1'b1, "R9 remote held after 127", remote_fault, 1);
      idle(1);
      check(remote_fault == 1'b0, "R9 remote clears on 128th", remote_fault, 0);

      // R10: external PHY fault
      check(link_up == 1'b1, "R11 relocked", link_up, 1);
      phy_fault = 1'b1;
      @(posedge clk); #1;
      phy_fault = 1'b0;
      check(local_fault && !link_up, "R10 phy fault", {local_fault, link_up}, 2);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule